// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block turns 32-bit virtual addresses into 36-bit physical addresses using two tiers of cached translations. A small fully associative first tier answers in the same cycle as the request. When the first tier misses, a larger four-way set-associative second tier is probed on the following cycles. A hit in the second tier also copies the entry into the first tier. Every entry records whether it maps a 4 KB page or a 4 MB page, so mappings of both sizes can be held at the same time.

The requester raises `req_valid` with `req_va` and holds both until `rsp_valid` is high for one sampled cycle. If neither tier holds the page, `walk_req` rises and the lookup waits. An external page walker then supplies the translation on the fill port. A fill writes both tiers, and the waiting lookup then completes from the first tier. `inv_all` empties both tiers in one cycle.

Top module: `tlb2_xlate`

## Requirements
- R1: Out of reset both tiers are empty. `rsp_valid` and `walk_req` are low while no lookup is pending, and the first lookup of any page raises `walk_req` with no response.
- R2: A first-tier hit on a 4 KB entry drives `rsp_valid` in the request cycle, with `rsp_pa = {ppn[23:0], req_va[11:0]}`.
- R3: A 4 MB entry matches on `req_va[31:22]` only and returns `{ppn[23:10], req_va[21:0]}`. Bits ppn[9:0] have no effect on the result.
- R4: A 4 KB entry matches on `req_va[31:12]`, so an address in the adjacent 4 KB page misses it.
- R5: On a first-tier miss, a 4 KB entry in the second tier, held in set `req_va[17:12]`, responds one cycle after the request. It is also written into the first tier, so a repeat lookup of the same page responds in its request cycle.
- R6: When the 4 KB probe misses, a 4 MB entry in the second tier, held in set `req_va[27:22]`, responds two cycles after the request.
- R7: When both probes miss, `walk_req` is high from the third cycle after the request and stays high until a fill arrives. The response comes in the cycle after the fill cycle.
- R8: The first tier holds 32 entries and replaces them in round-robin order of writes, counting both fills and refills. The 33rd write evicts the first entry written.
- R9: Each second-tier set replaces the way named by a 3-bit tree pseudo-LRU state. Both fills and accepted hits update that state, so a way hit recently survives the next fill into its full set.
- R10: One cycle of `inv_all` removes every entry from both tiers and returns a pending lookup to its first probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request, held until answered |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation available this cycle |
| rsp_pa | output | 36 | Translated physical address |
| walk_req | output | 1 | Both tiers missed; a page walk is needed |
| fill_valid | input | 1 | Write one translation this cycle |
| fill_va | input | 32 | Virtual address of the page being filled |
| fill_ppn | input | 24 | Physical page number (upper 14 bits used for 4 MB) |
| fill_big | input | 1 | 1 = 4 MB page, 0 = 4 KB page |
| inv_all | input | 1 | Drop every entry in both tiers |

## Verification
Each lookup carries a due cycle, counted from its request cycle:
- 0 for a first-tier hit,
- 1 for a 4 KB second-tier hit,
- 2 for a 4 MB second-tier hit,
- 5 when a walk is needed.

The walk case is 5 because `walk_req` is due in cycle 3 and the bench answers with a fill in cycle 4. The scoreboard counts cycles at the falling edge while the request is held. It pairs the first `rsp_valid` with the queued physical address and due cycle, so a result that arrives early or late is caught as well as a wrong one. The replacement sequences are arranged so that the expected tier and due cycle of every later lookup follow from the round-robin and tree pseudo-LRU rules alone.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 36;
  localparam int PG_S  = 12;            // small page offset bits
  localparam int PG_L  = 22;            // large page offset bits
  localparam int VPN_W = VA_W - PG_S;
  localparam int PPN_W = PA_W - PG_S;
  localparam int LSH   = PG_L - PG_S;   // page number bits covered by a large page

  typedef struct packed {
    logic             vld;
    logic             big;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } tlb_ent_t;

  function automatic logic ent_match(tlb_ent_t e, logic [VA_W-1:0] va);
    if (!e.vld) return 1'b0;
    if (e.big) return e.vpn[VPN_W-1:LSH] == va[VA_W-1:PG_L];
    return e.vpn == va[VA_W-1:PG_S];
  endfunction

  function automatic logic [PA_W-1:0] ent_pa(tlb_ent_t e, logic [VA_W-1:0] va);
    if (e.big) return {e.ppn[PPN_W-1:LSH], va[PG_L-1:0]};
    return {e.ppn, va[PG_S-1:0]};
  endfunction

  function automatic tlb_ent_t ent_make(logic [VA_W-1:0] va, logic [PPN_W-1:0] ppn,
                                        logic big);
    tlb_ent_t e;
    e.vld = 1'b1;
    e.big = big;
    e.vpn = va[VA_W-1:PG_S];
    e.ppn = ppn;
    return e;
  endfunction

  // 3-bit tree: t[0] picks the half holding the victim, t[1] the way within ways 0/1,
  // t[2] the way within ways 2/3
  function automatic logic [1:0] plru_victim(logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] plru_touch(logic [2:0] t, logic [1:0] w);
    logic [2:0] n;
    n = t;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/tlb2_l1.sv
module tlb2_l1
  import tlb2_pkg::*;
#(
  parameter int N = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv,
  input  logic [VA_W-1:0] lk_va,
  output logic            hit,
  output logic [PA_W-1:0] hit_pa,
  input  logic            wr_en,
  input  tlb_ent_t        wr_ent
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  tlb_ent_t         ents [N];
  logic [PTR_W-1:0] ptr;
  logic [N-1:0]     match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_match(ents[i], lk_va);
  end

  always_comb begin
    hit_pa = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) hit_pa = hit_pa | ent_pa(ents[i], lk_va);
  end
  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n || inv) begin
      for (int i = 0; i < N; i++) ents[i].vld <= 1'b0;
      if (!rst_n) ptr <= '0;
    end else if (wr_en) begin
      ents[ptr] <= wr_ent;
      ptr <= (ptr == PTR_W'(N-1)) ? '0 : ptr + 1'b1;
    end
  end

  AST_L1_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));                                              // R8
  AST_L1_INV_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> !hit);                                                 // R10
endmodule

// File: rtl/tlb2_l2.sv
module tlb2_l2
  import tlb2_pkg::*;
#(
  parameter int SETS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv,
  input  logic [VA_W-1:0] pr_va,
  input  logic            pr_big,
  input  logic            touch,
  output logic            hit,
  output tlb_ent_t        hit_ent,
  input  logic            fill_en,
  input  tlb_ent_t        fill_ent
);
  localparam int WAYS  = 4;   // replacement tree is written for four ways
  localparam int SET_W = $clog2(SETS);

  function automatic logic [SET_W-1:0] set_of(logic [VA_W-1:0] va, logic big);
    return big ? va[PG_L +: SET_W] : va[PG_S +: SET_W];
  endfunction

  tlb_ent_t         mem  [SETS][WAYS];
  logic [2:0]       tree [SETS];
  logic [SET_W-1:0] pr_set, f_set;
  logic [WAYS-1:0]  way_hit;
  logic [1:0]       hit_way, f_way;

  assign pr_set = set_of(pr_va, pr_big);
  assign f_set  = set_of({fill_ent.vpn, {PG_S{1'b0}}}, fill_ent.big);
  assign f_way  = plru_victim(tree[f_set]);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = ent_match(mem[pr_set][w], pr_va) && (mem[pr_set][w].big == pr_big);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hit_way = 2'(w);
  end
  assign hit     = |way_hit;
  assign hit_ent = mem[pr_set][hit_way];

  always_ff @(posedge clk) begin
    if (!rst_n || inv) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) mem[s][w].vld <= 1'b0;
        if (!rst_n) tree[s] <= '0;
      end
    end else begin
      if (touch && hit) tree[pr_set] <= plru_touch(tree[pr_set], hit_way);
      if (fill_en) begin
        mem[f_set][f_way] <= fill_ent;
        tree[f_set]       <= plru_touch(tree[f_set], f_way);
      end
    end
  end

  AST_L2_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));                                            // R9
  AST_L2_INV_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> !hit);                                                 // R10
endmodule

// File: rtl/tlb2_xlate.sv
module tlb2_xlate
  import tlb2_pkg::*;
#(
  parameter int L1_N    = 32,
  parameter int L2_SETS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  output logic        rsp_valid,
  output logic [35:0] rsp_pa,
  output logic        walk_req,
  input  logic        fill_valid,
  input  logic [31:0] fill_va,
  input  logic [23:0] fill_ppn,
  input  logic        fill_big,
  input  logic        inv_all
);
  typedef enum logic [1:0] {ST_IDLE, ST_P4K, ST_P4M, ST_WALK} st_t;
  st_t st;

  logic            l1_hit, l2_hit, probing, l2_take;
  logic [PA_W-1:0] l1_pa;
  tlb_ent_t        l2_ent, fill_ent, l1_wr_ent;

  assign probing   = (st == ST_P4K) || (st == ST_P4M);
  assign l2_take   = probing && req_valid && l2_hit;
  assign fill_ent  = ent_make(fill_va, fill_ppn, fill_big);
  assign l1_wr_ent = fill_valid ? fill_ent : l2_ent;

  tlb2_l1 #(.N(L1_N)) u_l1 (
    .clk(clk), .rst_n(rst_n), .inv(inv_all), .lk_va(req_va),
    .hit(l1_hit), .hit_pa(l1_pa),
    .wr_en(fill_valid || l2_take), .wr_ent(l1_wr_ent)
  );

  tlb2_l2 #(.SETS(L2_SETS)) u_l2 (
    .clk(clk), .rst_n(rst_n), .inv(inv_all), .pr_va(req_va),
    .pr_big(st == ST_P4M), .touch(l2_take), .hit(l2_hit), .hit_ent(l2_ent),
    .fill_en(fill_valid), .fill_ent(fill_ent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || inv_all) st <= ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE: if (req_valid && !l1_hit) st <= ST_P4K;
        ST_P4K:  st <= l2_take ? ST_IDLE : ST_P4M;
        ST_P4M:  st <= l2_take ? ST_IDLE : ST_WALK;
        ST_WALK: if (fill_valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = ((st == ST_IDLE) && req_valid && l1_hit) || l2_take;
  assign rsp_pa    = (st == ST_IDLE) ? l1_pa : ent_pa(l2_ent, req_va);
  assign walk_req  = (st == ST_WALK);

  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !fill_valid && !inv_all) |=> walk_req);           // R7
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_pa[11:0] == req_va[11:0]));                 // R2
  AST_NO_RSP_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !fill_valid) |=> !rsp_valid || !$past(walk_req) || $past(fill_valid)); // R7
endmodule

// File: tb/sim_tlb2_xlate.sv
module sim_tlb2_xlate;
  localparam int CLK_NS = 10;

  logic        clk, rst_n, req_valid, rsp_valid, walk_req, fill_valid, fill_big, inv_all;
  logic [31:0] req_va, fill_va;
  logic [35:0] rsp_pa;
  logic [23:0] fill_ppn;

  tlb2_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .walk_req(walk_req),
    .fill_valid(fill_valid), .fill_va(fill_va), .fill_ppn(fill_ppn),
    .fill_big(fill_big), .inv_all(inv_all)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [35:0] q_pa[$];
  int          q_lat[$];
  string       q_tag[$];
  bit          got;
  int          cyc;

  function automatic logic [35:0] pa_small(logic [23:0] ppn, logic [31:0] va);
    logic [63:0] x;
    x = (64'(ppn) << 12) + 64'(va % 4096);
    return x[35:0];
  endfunction

  function automatic logic [35:0] pa_large(logic [23:0] ppn, logic [31:0] va);
    logic [63:0] x;
    x = ((64'(ppn) / 1024) << 22) + 64'(va % 4194304);
    return x[35:0];
  endfunction

  function automatic logic [23:0] ppn_for(logic [19:0] vpn);
    return 24'hC00000 + 24'(vpn);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: pairs the first response of a request with the queued item
  always @(negedge clk) begin
    if (req_valid && !got) begin
      if (rsp_valid) begin
        if (q_pa.size() == 0) check(1'b0, "R1", "unexpected response", 0, 0);
        else begin
          logic [35:0] e;
          int l;
          string t;
          e = q_pa.pop_front(); l = q_lat.pop_front(); t = q_tag.pop_front();
          check(rsp_pa === e, t, "physical address", longint'(rsp_pa), longint'(e));
          check(cyc == l, t, "response cycle", cyc, l);
        end
        got = 1'b1;
      end else cyc++;
    end
  end

  task automatic do_fill(logic [31:0] va, logic [23:0] ppn, logic big);
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_va = va; fill_ppn = ppn; fill_big = big;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic lookup(logic [31:0] va, logic [35:0] epa, int elat, string tag,
                        bit ewalk, logic [23:0] wppn, logic big);
    int  n;
    bit  seen;
    q_pa.push_back(epa); q_lat.push_back(elat); q_tag.push_back(tag);
    @(posedge clk); #1;
    got = 1'b0; cyc = 0; req_valid = 1'b1; req_va = va;
    n = 0; seen = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (got) break;
      if (walk_req && !seen) begin
        seen = 1'b1;
        check(ewalk && n == 3, tag, "walk request cycle", n, ewalk ? 3 : -1);
        @(posedge clk); #1;
        fill_valid = 1'b1; fill_va = va; fill_ppn = wppn; fill_big = big;
        @(posedge clk); #1;
        fill_valid = 1'b0;
        n++;
      end
      n++;
      if (n > 60) begin
        check(1'b0, tag, "no response", n, elat);
        void'(q_pa.pop_front()); void'(q_lat.pop_front()); void'(q_tag.pop_front());
        break;
      end
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic flush(logic [19:0] base, int cnt);
    for (int i = 0; i < cnt; i++) begin
      logic [19:0] v;
      v = base + 20'(i + 8);
      do_fill({v, 12'h000}, ppn_for(v), 1'b0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 0);
    finish_run();
  end

  localparam logic [19:0] PA_ = 20'h00401, PB_ = 20'h00402;
  localparam logic [31:0] BIG_VA = 32'h803F_FABC;
  localparam logic [23:0] BIG_PPN = 24'h1234FF;

  initial begin
    logic [19:0] pg [5];
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; fill_valid = 1'b0;
    fill_va = '0; fill_ppn = '0; fill_big = 1'b0; inv_all = 1'b0; got = 1'b1; cyc = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid && !walk_req, "R1", "idle outputs after reset",
          {rsp_valid, walk_req}, 0);

    // R1 / R7: empty buffer walks, then answers one cycle after the fill
    lookup({PA_, 12'h234}, pa_small(ppn_for(PA_), {PA_, 12'h234}), 5, "R1", 1, ppn_for(PA_), 0);
    // R2: same page, another offset, same-cycle hit
    lookup({PA_, 12'hFFF}, pa_small(ppn_for(PA_), {PA_, 12'hFFF}), 0, "R2", 0, 0, 0);
    // R3: large page, low ppn bits ignored, offset bits 21:0 passed through
    do_fill(32'h8000_0000, BIG_PPN, 1'b1);
    lookup(BIG_VA, pa_large(BIG_PPN, BIG_VA), 0, "R3", 0, 0, 0);
    lookup(32'h8000_0001, pa_large(BIG_PPN, 32'h8000_0001), 0, "R3", 0, 0, 0);
    // R4: neighbouring small page misses and walks
    lookup({PB_, 12'h234}, pa_small(ppn_for(PB_), {PB_, 12'h234}), 5, "R4", 1, ppn_for(PB_), 0);
    // R8: 30 more writes make 33, evicting the first entry only
    flush(20'h20000, 30);
    lookup(BIG_VA, pa_large(BIG_PPN, BIG_VA), 0, "R8", 0, 0, 0);
    // R5: first page now from the second tier; its refill evicts the large page
    lookup({PA_, 12'h010}, pa_small(ppn_for(PA_), {PA_, 12'h010}), 1, "R5", 0, 0, 0);
    // R6: large page from the second tier; refill evicts page B
    lookup(BIG_VA, pa_large(BIG_PPN, BIG_VA), 2, "R6", 0, 0, 0);
    lookup({PB_, 12'h020}, pa_small(ppn_for(PB_), {PB_, 12'h020}), 1, "R5", 0, 0, 0);
    lookup({PA_, 12'h030}, pa_small(ppn_for(PA_), {PA_, 12'h030}), 0, "R5", 0, 0, 0);
    // R9: four pages in set 50, touch the first, a fifth fill must evict the second
    for (int k = 0; k < 5; k++) pg[k] = 20'h30032 + 20'(k * 64);
    for (int k = 0; k < 4; k++) do_fill({pg[k], 12'h000}, ppn_for(pg[k]), 1'b0);
    flush(20'h40000, 32);
    lookup({pg[0], 12'h444}, pa_small(ppn_for(pg[0]), {pg[0], 12'h444}), 1, "R9", 0, 0, 0);
    do_fill({pg[4], 12'h000}, ppn_for(pg[4]), 1'b0);
    flush(20'h50000, 32);
    lookup({pg[0], 12'h001}, pa_small(ppn_for(pg[0]), {pg[0], 12'h001}), 1, "R9", 0, 0, 0);
    lookup({pg[2], 12'h002}, pa_small(ppn_for(pg[2]), {pg[2], 12'h002}), 1, "R9", 0, 0, 0);
    lookup({pg[3], 12'h003}, pa_small(ppn_for(pg[3]), {pg[3], 12'h003}), 1, "R9", 0, 0, 0);
    lookup({pg[4], 12'h004}, pa_small(ppn_for(pg[4]), {pg[4], 12'h004}), 1, "R9", 0, 0, 0);
    lookup({pg[1], 12'h005}, pa_small(ppn_for(pg[1]), {pg[1], 12'h005}), 5, "R9", 1, ppn_for(pg[1]), 0);
    // R10: invalidate clears both tiers
    @(posedge clk); #1; inv_all = 1'b1;
    @(posedge clk); #1; inv_all = 1'b0;
    lookup({pg[1], 12'h006}, pa_small(ppn_for(pg[1]), {pg[1], 12'h006}), 5, "R10", 1, ppn_for(pg[1]), 0);
    lookup(BIG_VA, pa_large(BIG_PPN, BIG_VA), 5, "R10", 1, BIG_PPN, 1);
    lookup(32'h8012_3456, pa_large(BIG_PPN, 32'h8012_3456), 0, "R3", 0, 0, 0);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule